// File: doc/BRIEF.md
# Frame-programmable UART

A full-duplex asynchronous serial channel. One 8-bit control register sets the frame format at run time. The data length is 7 or 8 bits. An extra bit after the data can be left out, or it can carry odd or even parity. The frame ends with one or two stop bits. In multiprocessor mode, selected by the `multi_mode` input, the extra slot carries an address/data marker instead of parity. The same register holds separate enables for the transmitter and the receiver, and a write-only bit that clears the three receive error flags.

A host writes the register through a single write strobe and reads it back on `reg_rdata`. Bytes to send are offered on a valid/ready pair. Received bytes appear on `rx_data` together with the received marker on `rx_addr`. They are held, with `rx_valid` high, until the host pulses `rx_take`. Bit timing comes from an external `baud_tick` strobe that runs at 16 times the bit rate.

Top module: `frame_uart`

## Requirements
- R1: After reset, `reg_rdata` reads 0x04, `txd` is high, `tx_ready` is low, `rx_valid` is low and all three error flags are low.
- R2: Control bits: bit 0 enables the transmitter and bit 1 enables the receiver. Bit 2 is the write-only error clear. Bit 3 is the marker value, with 0 for data and 1 for address. Bit 4 selects the data length, with 0 for 7 bits and 1 for 8 bits. Bit 5 selects the stop bits, with 0 for one and 1 for two. Bit 6 selects the parity sense, with 0 for even and 1 for odd. Bit 7 enables parity. A read returns the last written value with bit 2 shown as 1.
- R3: A byte is accepted when `tx_valid` and `tx_ready` are both high. It is sent as a low start bit, then the data bits LSB first (7 or 8 of them, per bit 4), then the stop bits. Every bit lasts 16 `baud_tick` pulses, and the line idles high.
- R4: With bit 7 set and `multi_mode` low, a parity bit follows the data. It makes the count of ones in the data and parity bit even when bit 6 is 0, and odd when bit 6 is 1.
- R5: Bit 5 set gives two high stop bits; clear gives one.
- R6: With `multi_mode` high, the slot after the data always carries bit 3, whatever bit 7 holds. On reception, the value found in that slot appears on `rx_addr` with the byte. No parity is added or checked in this mode.
- R7: The receiver samples each bit at its middle, 8 ticks after it detects the start edge and every 16 ticks after that. It delivers the byte with the unused top bit at 0 in 7-bit mode. `rx_valid` and `rx_data` hold until `rx_take`.
- R8: `err_frame` is set when any stop bit is sampled low. `err_parity` is set when the received parity does not match the selected sense.
- R9: When a frame completes while `rx_valid` is high and `rx_take` is low, `err_overrun` is set and the held byte is kept.
- R10: A write with bit 2 at 0 clears all three error flags. A write with bit 2 at 1 leaves them unchanged.
- R11: When an error is raised in the same cycle as a clearing write, the error flag ends up set.
- R12: With bit 0 at 0, `tx_ready` stays low and `txd` stays high. With bit 1 at 0, activity on `rxd` delivers no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Strobe at 16x the bit rate |
| multi_mode | input | 1 | Slot after the data carries the address/data marker |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write value |
| reg_rdata | output | 8 | Control register read value |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter can take a byte |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received byte |
| rx_addr | output | 1 | Received marker bit |
| rx_valid | output | 1 | Received byte waiting |
| rx_take | input | 1 | Host consumes the received byte |
| err_frame | output | 1 | Framing error flag |
| err_overrun | output | 1 | Overrun error flag |
| err_parity | output | 1 | Parity error flag |

## Verification
A clearing register write and the receiver raising an error can fall in the same cycle. The bench provokes this by holding a write with bit 2 at 0 on every cycle while a frame with a low stop bit is received. It stops writing as soon as `err_frame` is seen high. The flag must rise even though a clearing write is active at that edge, and it must stay high afterwards. A further single clearing write must then bring it back to 0.

// File: rtl/frame_uart_pkg.sv
package frame_uart_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 12;

  typedef struct packed {
    logic par_on;
    logic par_odd;
    logic stop2;
    logic len8;
    logic adr_mark;
    logic clr_n;
    logic rx_on;
    logic tx_on;
  } ctl_t;

  localparam ctl_t CTL_RESET = ctl_t'(8'h04);

  // total line bits in one frame for a given setting
  function automatic logic [3:0] frame_bits(ctl_t c, logic mp);
    logic [3:0] n;
    n = 4'd1 + (c.len8 ? 4'd8 : 4'd7);
    if (c.par_on || mp) n = n + 4'd1;
    n = n + (c.stop2 ? 4'd2 : 4'd1);
    return n;
  endfunction
endpackage

// File: rtl/frame_uart_ctl.sv
module frame_uart_ctl
  import frame_uart_pkg::*;
#(
  parameter int N_ERR = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [N_ERR-1:0] err_set,
  output ctl_t             ctl,
  output logic [N_ERR-1:0] err
);
  logic clr;
  assign clr = wr_en && !wr_data[2];

  always_ff @(posedge clk) begin
    if (rst) ctl <= CTL_RESET;
    else if (wr_en) ctl <= ctl_t'({wr_data[7:3], 1'b1, wr_data[1:0]});
  end

  for (genvar g = 0; g < N_ERR; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) err[g] <= 1'b0;
      else     err[g] <= (err[g] && !clr) || err_set[g];
    end

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
      err_set[g] |=> err[g]);
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_data[2] && !err_set[g]) |=> !err[g]);
  end
endmodule

// File: rtl/frame_uart_tx.sv
module frame_uart_tx
  import frame_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  ctl_t             ctl,
  input  logic             mp,
  input  logic [DATA_W-1:0] data,
  input  logic             valid,
  output logic             ready,
  output logic             txd
);
  localparam int CNT_W = $clog2(OVS);

  logic               busy;
  logic [FRAME_W-1:0] sh;
  logic [FRAME_W-1:0] frame;
  logic [3:0]         left;
  logic [CNT_W-1:0]   cnt;
  logic [7:0]         d;
  logic               slot_en, slot_v;

  always_comb begin
    d       = ctl.len8 ? data : {1'b0, data[6:0]};
    slot_en = ctl.par_on || mp;
    slot_v  = mp ? ctl.adr_mark : ((^d) ^ ctl.par_odd);
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || ctl.len8) frame[i+1] = d[i];
    if (slot_en) frame[ctl.len8 ? 9 : 8] = slot_v;
  end

  assign ready = ctl.tx_on && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      cnt  <= '0;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (valid && ready) begin
        sh   <= frame;
        left <= frame_bits(ctl, mp);
        cnt  <= '0;
        busy <= 1'b1;
        txd  <= frame[0];
      end
    end else if (tick) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(OVS-1)) begin
        sh   <= {1'b1, sh[FRAME_W-1:1]};
        txd  <= sh[1];
        left <= left - 4'd1;
        if (left == 4'd1) busy <= 1'b0;
      end
    end
  end

  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  a_r12_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
endmodule

// File: rtl/frame_uart_rx.sv
module frame_uart_rx
  import frame_uart_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  ctl_t             ctl,
  input  logic             mp,
  input  logic             rxd,
  input  logic             take,
  output logic [DATA_W-1:0] data,
  output logic             addr,
  output logic             valid,
  output logic             done,
  output logic             fe_set,
  output logic             pe_set,
  output logic             oe_set
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS/2 - 1);

  logic [SYNC-1:0]  sy;
  logic             line;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [3:0]       idx, last, dlen;
  logic             c_len8, c_par, c_odd, c_mp, c_slot;
  logic [7:0]       shreg;
  logic             slot, stop_bad;

  assign line = sy[SYNC-1];
  assign dlen = c_len8 ? 4'd8 : 4'd7;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy       <= '1;
      active   <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      last     <= '0;
      c_len8   <= 1'b0;
      c_par    <= 1'b0;
      c_odd    <= 1'b0;
      c_mp     <= 1'b0;
      c_slot   <= 1'b0;
      shreg    <= '0;
      slot     <= 1'b0;
      stop_bad <= 1'b0;
      done     <= 1'b0;
      fe_set   <= 1'b0;
      pe_set   <= 1'b0;
    end else begin
      sy     <= {sy[SYNC-2:0], rxd};
      done   <= 1'b0;
      fe_set <= 1'b0;
      pe_set <= 1'b0;
      if (!active) begin
        if (tick && ctl.rx_on && !line) begin
          active   <= 1'b1;
          cnt      <= '0;
          idx      <= '0;
          last     <= frame_bits(ctl, mp) - 4'd1;
          c_len8   <= ctl.len8;
          c_par    <= ctl.par_on;
          c_odd    <= ctl.par_odd;
          c_mp     <= mp;
          c_slot   <= ctl.par_on || mp;
          shreg    <= '0;
          slot     <= 1'b0;
          stop_bad <= 1'b0;
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        if (cnt == HALF) begin
          idx <= idx + 4'd1;
          if (idx == 4'd0) begin
            if (line) active <= 1'b0;      // false start
          end else if (idx <= dlen) begin
            shreg[3'(idx - 4'd1)] <= line;
          end else if (c_slot && idx == dlen + 4'd1) begin
            slot <= line;
          end else begin
            if (!line) stop_bad <= 1'b1;
            if (idx == last) begin
              active <= 1'b0;
              done   <= 1'b1;
              fe_set <= stop_bad || !line;
              pe_set <= c_par && !c_mp && (((^shreg) ^ slot) != c_odd);
            end
          end
        end
      end
    end
  end

  // delivery stage, one cycle after frame completion
  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      addr   <= 1'b0;
      valid  <= 1'b0;
      oe_set <= 1'b0;
    end else begin
      oe_set <= 1'b0;
      if (valid && take) valid <= 1'b0;
      if (done) begin
        if (valid && !take) oe_set <= 1'b1;
        else begin
          data  <= shreg;
          addr  <= c_mp ? slot : 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !take) |=> (valid && $stable(data)));
endmodule

// File: rtl/frame_uart.sv
module frame_uart
  import frame_uart_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       multi_mode,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  output logic [7:0] rx_data,
  output logic       rx_addr,
  output logic       rx_valid,
  input  logic       rx_take,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       err_parity
);
  ctl_t       ctl;
  logic [2:0] err, err_set;
  logic       rx_done, fe_set, pe_set, oe_set;

  assign err_set     = {pe_set, oe_set, fe_set};
  assign err_frame   = err[0];
  assign err_overrun = err[1];
  assign err_parity  = err[2];
  assign reg_rdata   = ctl;

  frame_uart_ctl #(.N_ERR(3)) u_ctl (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_data(reg_wdata),
    .err_set(err_set), .ctl(ctl), .err(err)
  );

  frame_uart_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .tick(baud_tick), .ctl(ctl), .mp(multi_mode),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
  );

  frame_uart_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
    .clk(clk), .rst(rst), .tick(baud_tick), .ctl(ctl), .mp(multi_mode),
    .rxd(rxd), .take(rx_take), .data(rx_data), .addr(rx_addr),
    .valid(rx_valid), .done(rx_done), .fe_set(fe_set), .pe_set(pe_set),
    .oe_set(oe_set)
  );

  a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_valid && !rx_take) |=> ##1 (err_overrun && rx_valid));
endmodule

// File: tb/frame_uart_bench.sv
module frame_uart_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, baud_tick = 0, multi_mode = 0;
  logic reg_wr = 0, tx_valid = 0, rxd = 1, rx_take;
  logic [7:0] reg_wdata = 0, tx_data = 0, reg_rdata, rx_data;
  logic tx_ready, txd, rx_addr, rx_valid, err_frame, err_overrun, err_parity;

  int n_checks = 0, n_fail = 0;
  logic [7:0] ctl_shadow = 8'h04;
  bit auto_take = 1;
  string tx_tag = "R3";

  typedef struct { int n; logic [11:0] b; string tag; } txe_t;
  typedef struct { logic [7:0] d; logic a; string tag; } rxe_t;
  txe_t txq[$];
  rxe_t rxq[$];

  frame_uart u_frame_uart (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .multi_mode(multi_mode),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd), .rx_data(rx_data), .rx_addr(rx_addr), .rx_valid(rx_valid),
    .rx_take(rx_take), .err_frame(err_frame), .err_overrun(err_overrun),
    .err_parity(err_parity)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) baud_tick <= rst ? 1'b0 : ~baud_tick;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
    ctl_shadow = {v[7:3], 1'b1, v[1:0]};
  endtask

  function automatic void exp_tx(input logic [7:0] c, input bit mp, input logic [7:0] d,
                                 output int n, output logic [11:0] b);
    int dl = c[4] ? 8 : 7;
    int k = 1;
    bit ones = 0;
    b = '1; b[0] = 0;
    for (int i = 0; i < dl; i++) begin b[k] = d[i]; ones ^= d[i]; k++; end
    if (mp) begin b[k] = c[3]; k++; end
    else if (c[7]) begin b[k] = ones ^ c[6]; k++; end
    k += c[5] ? 2 : 1;
    n = k;
  endfunction

  task automatic send_tx(input logic [7:0] d);
    txe_t e;
    exp_tx(ctl_shadow, multi_mode, d, e.n, e.b);
    e.tag = tx_tag;
    txq.push_back(e);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_data = d; tx_valid = 1;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic drain_tx();
    while (txq.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  task automatic drive_bit(input logic v);
    @(negedge clk); rxd = v;
    repeat (31) @(negedge clk);
  endtask

  // slot < 0: no slot bit
  task automatic rx_frame(input logic [7:0] d, input int dl, input int slot,
                          input int nstop, input bit bad_stop);
    drive_bit(0);
    for (int i = 0; i < dl; i++) drive_bit(d[i]);
    if (slot >= 0) drive_bit(slot[0]);
    for (int s = 0; s < nstop; s++) drive_bit(!(bad_stop && s == nstop - 1));
    drive_bit(1);
    repeat (8) @(negedge clk);
  endtask

  function automatic bit ones_of(input logic [7:0] d, input int dl);
    bit p = 0;
    for (int i = 0; i < dl; i++) p ^= d[i];
    return p;
  endfunction

  task automatic expect_rx(input logic [7:0] d, input logic a, input string tag);
    rxe_t r; r.d = d; r.a = a; r.tag = tag;
    rxq.push_back(r);
  endtask

  // TX scoreboard monitor
  initial begin
    txe_t e;
    logic [11:0] got;
    forever begin
      @(negedge clk);
      if (!rst && txd === 1'b0) begin
        if (txq.size() == 0) begin
          check(0, "R12 start bit with nothing queued", 0, 1);
          while (txd === 1'b0) @(negedge clk);
        end else begin
          e = txq[0];
          got = '1;
          repeat (16) @(negedge clk);
          for (int i = 0; i < e.n; i++) begin
            got[i] = txd;
            if (i < e.n - 1) repeat (32) @(negedge clk);
          end
          check(got == e.b, e.tag, int'(got), int'(e.b));
          void'(txq.pop_front());
        end
      end
    end
  end

  // RX scoreboard monitor
  initial begin
    rxe_t r;
    rx_take = 0;
    forever begin
      @(negedge clk);
      if (!rst && rx_valid && auto_take) begin
        if (rxq.size() == 0) check(0, "R7 unexpected byte", int'(rx_data), 0);
        else begin
          r = rxq.pop_front();
          check(rx_data == r.d && rx_addr == r.a, r.tag,
                int'({rx_addr, rx_data}), int'({r.a, r.d}));
        end
        rx_take = 1;
        @(negedge clk); rx_take = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int guard;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(reg_rdata == 8'h04, "R1 reset register", reg_rdata, 8'h04);
    check(txd && !tx_ready && !rx_valid, "R1 idle outputs",
          {txd, tx_ready, rx_valid}, 3'b100);
    check({err_frame, err_overrun, err_parity} == 3'b000, "R1 flags",
          {err_frame, err_overrun, err_parity}, 0);

    // R2 readback, write-only bit reads 1
    write_ctl(8'h03);
    check(reg_rdata == 8'h07, "R2 readback", reg_rdata, 8'h07);

    // R3 7-bit no parity one stop
    tx_tag = "R3 7N1 frame";
    send_tx(8'h55);
    send_tx(8'hA3);
    drain_tx();

    // R4 odd parity 8 bits, R5 two stop bits with even parity
    write_ctl(8'hD7);
    tx_tag = "R4 8O1 frame";
    send_tx(8'h3C);
    drain_tx();
    write_ctl(8'hB7);
    tx_tag = "R5 8E2 frame";
    send_tx(8'h81);
    drain_tx();

    // R6 marker slot, 7 bits two stops, marker 1
    multi_mode = 1;
    write_ctl(8'h2F);
    tx_tag = "R6 marker frame";
    send_tx(8'h12);
    drain_tx();
    expect_rx(8'h45, 1'b1, "R6 received marker");
    rx_frame(8'h45, 7, 1, 2, 0);
    check(err_parity == 0, "R6 no parity check", err_parity, 0);
    multi_mode = 0;

    // R7 reception 8N1 and 7N1
    write_ctl(8'h17);
    expect_rx(8'hC9, 1'b0, "R7 8-bit byte");
    rx_frame(8'hC9, 8, -1, 1, 0);
    write_ctl(8'h07);
    expect_rx(8'h7F, 1'b0, "R7 7-bit byte");
    rx_frame(8'hFF, 7, -1, 1, 0);

    // R8 parity error, even sense
    write_ctl(8'h97);
    expect_rx(8'h5A, 1'b0, "R8 byte with bad parity");
    rx_frame(8'h5A, 8, int'(!ones_of(8'h5A, 8)), 1, 0);
    check(err_parity && !err_frame, "R8 parity flag",
          {err_parity, err_frame}, 2'b10);
    write_ctl(8'h93);
    check(!err_parity, "R10 clear parity flag", err_parity, 0);

    // R8 framing error, R10 keep with bit2=1
    write_ctl(8'h97);
    expect_rx(8'h0F, 1'b0, "R8 byte with low stop");
    rx_frame(8'h0F, 8, int'(ones_of(8'h0F, 8)), 1, 1);
    check(err_frame && !err_parity, "R8 framing flag",
          {err_frame, err_parity}, 2'b10);
    write_ctl(8'h97);
    check(err_frame, "R10 bit2 high keeps flag", err_frame, 1);
    write_ctl(8'h93);
    check(!err_frame, "R10 clear framing flag", err_frame, 0);

    // R9 overrun
    write_ctl(8'h17);
    auto_take = 0;
    rx_frame(8'h11, 8, -1, 1, 0);
    rx_frame(8'h22, 8, -1, 1, 0);
    check(rx_valid && rx_data == 8'h11, "R9 held byte kept", rx_data, 8'h11);
    check(err_overrun, "R9 overrun flag", err_overrun, 1);
    expect_rx(8'h11, 1'b0, "R9 held byte delivered");
    auto_take = 1;
    repeat (4) @(negedge clk);
    write_ctl(8'h13);
    write_ctl(8'h17);

    // R11 clear collides with framing error
    expect_rx(8'h66, 1'b0, "R11 byte");
    guard = 0;
    fork
      rx_frame(8'h66, 8, -1, 1, 1);
      begin
        @(negedge clk); reg_wr = 1; reg_wdata = 8'h13;
        while (!err_frame && guard < 2000) begin @(negedge clk); guard++; end
        reg_wr = 0;
      end
    join
    check(err_frame && guard < 2000, "R11 set wins over clear", err_frame, 1);
    repeat (4) @(negedge clk);
    check(err_frame, "R11 flag stays set", err_frame, 1);
    write_ctl(8'h17);
    write_ctl(8'h13);
    check(!err_frame, "R10 clear after collision", err_frame, 0);

    // R12 transmitter disabled
    write_ctl(8'h06);
    @(negedge clk); tx_data = 8'h00; tx_valid = 1;
    repeat (100) @(negedge clk);
    check(!tx_ready && txd, "R12 tx off", {tx_ready, txd}, 2'b01);
    tx_valid = 0;
    // R12 receiver disabled
    write_ctl(8'h05);
    rx_frame(8'h00, 8, -1, 1, 0);
    repeat (40) @(negedge clk);
    check(!rx_valid, "R12 rx off no byte", rx_valid, 0);
    check(rxq.size() == 0 && txq.size() == 0, "R7 scoreboards drained",
          rxq.size() + txq.size(), 0);
    finish_run();
  end
endmodule